// File: doc/BRIEF.md
# Floating-Point Control and Status Register Block

This block holds the architectural control and status state of a floating-point unit. It keeps a 3-bit dynamic rounding-mode field and a 5-bit set of sticky exception flags. It also keeps the 2-bit floating-point context state that normally lives in the machine status register. Software reaches this state through a CSR-style port with four selectable views. Execution units report raised exceptions as one-cycle flag-set pulses, and the register-file write path signals when a floating-point register was modified.

The context field is Off after reset. A build-time policy decides whether hardware moves the context field to Dirty. With the precise policy, any floating-point register write, and any software write to the rounding-mode or flag state, drives it to Dirty. With the none policy, only software changes the context field. A build-time mask lists which context values software may write. A write of any other value is dropped.

Top module: `fp_csr_regs`

## Requirements
- R1: After reset the rounding mode, the flags and the context field are all zero, and every view reads zero.
- R2: View select 0 is the combined view. It reads {24'b0, rounding mode, flags}, with the rounding mode at bits 7:5 and the flags at bits 4:0. A write to it loads both fields from the same positions.
- R3: View select 1 reads the flags at bits 4:0. Select 2 reads the rounding mode at bits 2:0. Select 3 reads the context field at bits 1:0. All higher bits read zero, and writes to each view load only its own field from the same low bits.
- R4: The flag bits are inexact at bit 0, underflow at bit 1, overflow at bit 2, divide-by-zero at bit 3 and invalid at bit 4. A flag-set pulse ORs its bits into the flags.
- R5: Flags stay set after the pulse ends. Only a software write through view 0 or 1 clears them.
- R6: When a flag-set pulse and a software flag write fall in the same cycle, the flags become the written value ORed with the pulse bits.
- R7: Under the precise policy (DIRTY_POLICY=1), a floating-point register write makes the context field read 3 (Dirty) right after that clock edge.
- R8: Under the precise policy, a software write through view 0, 1 or 2 also sets the context field to 3.
- R9: A software write of a context value whose bit in FS_LEGAL_MASK is clear is ignored, and the field keeps its value. Value 0 is always legal, and value 3 must be legal whenever a hardware policy is chosen.
- R10: Under the none policy (DIRTY_POLICY=0), register writes and writes through views 0 to 2 never change the context field.
- R11: Under the precise policy, when a register write and a software context write fall in the same cycle, the field becomes 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_sel | input | 2 | View select: 0 combined, 1 flags, 2 rounding mode, 3 context |
| csr_wr | input | 1 | Software write strobe for the selected view |
| csr_wdata | input | 32 | Software write data |
| csr_rdata | output | 32 | Read data of the selected view |
| hw_flag_set | input | 5 | Exception flag-set pulse from execution units |
| fpr_write | input | 1 | A floating-point register was modified this cycle |
| rm_out | output | 3 | Current dynamic rounding mode |
| flags_out | output | 5 | Current sticky exception flags |
| fs_out | output | 2 | Current floating-point context state |

## Verification
Two pairs of functions can land in the same clock cycle. The first is a flag-set pulse together with a software write of the flags. The second is a register-write notice together with a software write of the context field. The bench creates each collision by driving both strobes for one cycle. It then judges the result after that edge: the flags must equal the written value ORed with the pulse, and the context field must read Dirty under the precise policy. A second instance built with the none policy receives the same stimulus, which shows that hardware leaves its context field untouched.

// File: rtl/fp_csr_regs.sv
module fp_csr_regs #(
  parameter int         DIRTY_POLICY  = 1,
  parameter logic [3:0] FS_LEGAL_MASK = 4'b1011
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  csr_sel,
  input  logic        csr_wr,
  input  logic [31:0] csr_wdata,
  output logic [31:0] csr_rdata,
  input  logic [4:0]  hw_flag_set,
  input  logic        fpr_write,
  output logic [2:0]  rm_out,
  output logic [4:0]  flags_out,
  output logic [1:0]  fs_out
);
  localparam logic [1:0] SEL_ALL   = 2'd0;
  localparam logic [1:0] SEL_FLAGS = 2'd1;
  localparam logic [1:0] SEL_RM    = 2'd2;
  localparam logic [1:0] SEL_FS    = 2'd3;
  localparam logic [1:0] FS_DIRTY  = 2'd3;
  localparam bit         PRECISE   = (DIRTY_POLICY == 1);

  generate
    if (!FS_LEGAL_MASK[0] || (DIRTY_POLICY != 0 && !FS_LEGAL_MASK[3]))
      $error("fp_csr_regs: FS_LEGAL_MASK must allow Off, and Dirty under a hardware policy");
  endgenerate

  logic [2:0] rm_q;
  logic [4:0] flags_q;
  logic [1:0] fs_q;

  wire wr_all   = csr_wr && (csr_sel == SEL_ALL);
  wire wr_flags = csr_wr && (csr_sel == SEL_FLAGS);
  wire wr_rm    = csr_wr && (csr_sel == SEL_RM);
  wire wr_fs    = csr_wr && (csr_sel == SEL_FS);
  wire fs_legal = FS_LEGAL_MASK[csr_wdata[1:0]];
  wire hw_dirty = PRECISE && (fpr_write || wr_all || wr_flags || wr_rm);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rm_q    <= '0;
      flags_q <= '0;
      fs_q    <= '0;
    end else begin
      if (wr_all)     rm_q <= csr_wdata[7:5];
      else if (wr_rm) rm_q <= csr_wdata[2:0];

      if (wr_all || wr_flags) flags_q <= csr_wdata[4:0] | hw_flag_set;
      else                    flags_q <= flags_q | hw_flag_set;

      if (hw_dirty)              fs_q <= FS_DIRTY;
      else if (wr_fs && fs_legal) fs_q <= csr_wdata[1:0];
    end
  end

  always_comb begin
    case (csr_sel)
      SEL_ALL:   csr_rdata = {24'b0, rm_q, flags_q};
      SEL_FLAGS: csr_rdata = {27'b0, flags_q};
      SEL_RM:    csr_rdata = {29'b0, rm_q};
      default:   csr_rdata = {30'b0, fs_q};
    endcase
  end

  assign rm_out    = rm_q;
  assign flags_out = flags_q;
  assign fs_out    = fs_q;

  assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rdata[31:8] == 24'b0);

  assert_flag_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags_out & $past(hw_flag_set)) == $past(hw_flag_set)));

  assert_flags_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(csr_wr && (csr_sel == 2'd0 || csr_sel == 2'd1))
      |=> ((flags_out & $past(flags_out)) == $past(flags_out)));

  assert_illegal_fs_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr && csr_sel == 2'd3 && !FS_LEGAL_MASK[csr_wdata[1:0]] && !(PRECISE && fpr_write))
      |=> $stable(fs_out));

  generate
    if (DIRTY_POLICY == 1) begin : g_precise_chk
      assert_dirty_on_fpr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fpr_write |=> (fs_out == 2'd3));
      assert_dirty_on_csr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr && csr_sel != 2'd3) |=> (fs_out == 2'd3));
    end else if (DIRTY_POLICY == 0) begin : g_none_chk
      assert_hw_never_writes_fs_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(csr_wr && csr_sel == 2'd3) |=> $stable(fs_out));
    end
  endgenerate
endmodule

// File: tb/fp_csr_regs_tb.sv
module fp_csr_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  csr_sel;
  logic        csr_wr;
  logic [31:0] csr_wdata;
  logic [4:0]  hw_flag_set;
  logic        fpr_write;
  logic [31:0] rdata_p, rdata_n;
  logic [2:0]  rm_p, rm_n;
  logic [4:0]  fl_p, fl_n;
  logic [1:0]  fs_p, fs_n;
  int vectors = 0;
  int miscompares = 0;

  always #2 clk = ~clk;

  fp_csr_regs #(.DIRTY_POLICY(1), .FS_LEGAL_MASK(4'b1011)) u_dut (
    .clk(clk), .rst_n(rst_n), .csr_sel(csr_sel), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
    .csr_rdata(rdata_p), .hw_flag_set(hw_flag_set), .fpr_write(fpr_write),
    .rm_out(rm_p), .flags_out(fl_p), .fs_out(fs_p));

  fp_csr_regs #(.DIRTY_POLICY(0), .FS_LEGAL_MASK(4'b1001)) u_dut_np (
    .clk(clk), .rst_n(rst_n), .csr_sel(csr_sel), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
    .csr_rdata(rdata_n), .hw_flag_set(hw_flag_set), .fpr_write(fpr_write),
    .rm_out(rm_n), .flags_out(fl_n), .fs_out(fs_n));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic wr, input logic [1:0] sel, input logic [31:0] d,
                      input logic [4:0] hw, input logic fw);
    @(negedge clk);
    csr_wr = wr; csr_sel = sel; csr_wdata = d; hw_flag_set = hw; fpr_write = fw;
    @(posedge clk); #1;
    csr_wr = 1'b0; hw_flag_set = '0; fpr_write = 1'b0;
  endtask

  task automatic view(input logic [1:0] sel);
    @(negedge clk);
    csr_sel = sel; #1;
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0; csr_wr = 1'b0; csr_sel = '0; csr_wdata = '0; hw_flag_set = '0; fpr_write = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    rst_n = 1'b1;
  endtask

  task automatic t_reset;
    do_reset();
    chk("R1 rm", {29'b0, rm_p}, 0);
    chk("R1 flags", {27'b0, fl_p}, 0);
    chk("R1 fs", {30'b0, fs_p}, 0);
    for (int s = 0; s < 4; s++) begin
      view(s[1:0]);
      chk("R1 rdata", rdata_p, 0);
    end
  endtask

  task automatic t_hw_flags;
    logic [4:0] acc = '0;
    do_reset();
    for (int i = 0; i < 5; i++) begin
      step(1'b0, 2'd0, 0, 5'b1 << i, 1'b0);
      acc |= 5'b1 << i;
      chk("R4 flag bit", {27'b0, fl_p}, {27'b0, acc});
    end
    step(1'b0, 2'd0, 0, 0, 1'b0);
    step(1'b0, 2'd0, 0, 0, 1'b0);
    chk("R5 sticky", {27'b0, fl_p}, 32'h1f);
    view(2'd1);
    chk("R3 flags view", rdata_p, 32'h1f);
    step(1'b1, 2'd1, 32'h0000_0004, 0, 1'b0);
    chk("R5 sw clear", {27'b0, fl_p}, 32'h04);
    chk("R8 flags write dirty", {30'b0, fs_p}, 3);
    chk("R10 none flags write", {30'b0, fs_n}, 0);
  endtask

  task automatic t_combined;
    do_reset();
    step(1'b1, 2'd0, 32'hFFFF_FFB5, 0, 1'b0);
    chk("R2 rm", {29'b0, rm_p}, 5);
    chk("R2 flags", {27'b0, fl_p}, 32'h15);
    view(2'd0);
    chk("R2 combined read", rdata_p, 32'hB5);
    view(2'd2);
    chk("R3 rm view", rdata_p, 5);
    chk("R8 combined write dirty", {30'b0, fs_p}, 3);
    chk("R10 none combined write", {30'b0, fs_n}, 0);
    step(1'b1, 2'd2, 32'hFFFF_FFFA, 0, 1'b0);
    chk("R3 rm write", {29'b0, rm_p}, 2);
    chk("R3 rm write keeps flags", {27'b0, fl_p}, 32'h15);
  endtask

  task automatic t_same_cycle;
    do_reset();
    step(1'b0, 2'd0, 0, 5'b00110, 1'b0);
    step(1'b1, 2'd1, 32'h0000_0001, 5'b10000, 1'b0);
    chk("R6 or merge flags view", {27'b0, fl_p}, 32'h11);
    step(1'b1, 2'd0, 32'h0000_0060, 5'b01000, 1'b0);
    chk("R6 or merge combined", {27'b0, fl_p}, 32'h08);
    chk("R6 rm from combined", {29'b0, rm_p}, 3);
  endtask

  task automatic t_fpr;
    do_reset();
    step(1'b0, 2'd0, 0, 0, 1'b1);
    chk("R7 fpr dirty", {30'b0, fs_p}, 3);
    chk("R10 none fpr", {30'b0, fs_n}, 0);
    view(2'd3);
    chk("R3 fs view", rdata_p, 3);
  endtask

  task automatic t_fs_write;
    do_reset();
    step(1'b1, 2'd3, 32'h0000_0001, 0, 1'b0);
    chk("R9 legal fs", {30'b0, fs_p}, 1);
    chk("R9 illegal fs none", {30'b0, fs_n}, 0);
    step(1'b1, 2'd3, 32'h0000_0002, 0, 1'b0);
    chk("R9 illegal fs", {30'b0, fs_p}, 1);
    step(1'b1, 2'd3, 32'h0000_0003, 0, 1'b0);
    chk("R9 write dirty", {30'b0, fs_p}, 3);
    chk("R9 write dirty none", {30'b0, fs_n}, 3);
    step(1'b1, 2'd3, 32'h0000_0000, 0, 1'b0);
    chk("R9 write off", {30'b0, fs_p}, 0);
    chk("R9 write off none", {30'b0, fs_n}, 0);
    step(1'b1, 2'd3, 32'h0000_0000, 0, 1'b1);
    chk("R11 collision dirty", {30'b0, fs_p}, 3);
    chk("R10 collision none", {30'b0, fs_n}, 0);
  endtask

  initial begin
    #(4 * 20000);
    miscompares++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    t_reset();
    t_hw_flags();
    t_combined();
    t_same_cycle();
    t_fpr();
    t_fs_write();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule